// File: doc/BRIEF.md
# Dual-Cell Output Combiner

This block takes the accumulated 28-bit results of two filter cells and turns them into the final output word. A 2-bit mode control picks the combination: the sum of both cells, either cell alone, or the difference of the two. The mode is captured on the datapath clock. A rounding stage, switched on by an enable input, follows the combiner. It rounds the result at a chosen bit position. A format input sets whether the cell results and the output are two's complement or unsigned. The result is clamped to the 28-bit range of that format.

The registered output word is split into two fields with separate active-low three-state enables. Bits 27..9 go to a dedicated 19-bit output bus. Bits 8..0 are driven onto bits 9..1 of the second cell's 10-bit input bus, which makes that bus bidirectional. Bit 0 of the shared bus is only ever an input. The bus value is passed back out as the second cell's input sample.

Top module: `fir_pair_out_stage`

## Requirements
- R1: While `rstN` is low the output register clears to 0 and the registered mode clears to 00 (sum).
- R2: With registered mode 00, the output is the sum cellA + cellB.
- R3: With registered mode 01 the output is cellA alone. With registered mode 10 it is cellB alone.
- R4: With registered mode 11, the output is cellA − cellB.
- R5: `modeSel` is registered. A mode applied before clock edge k governs the result captured at edge k+1, while cell data applied before edge k is captured at edge k.
- R6: With `fmtUnsigned` = 0, inputs and output are two's complement. Results outside [−2^27, 2^27−1] clamp to the nearest limit.
- R7: With `fmtUnsigned` = 1, inputs and output are unsigned. A negative result gives 0, and a result above 2^28−1 gives 2^28−1.
- R8: With `roundEn` = 1 and effective position p = min(`roundPos`, 27), 2^(p−1) is added when p > 0 and bits below p are then cleared, before clamping. Position 0 leaves the value unchanged. With `roundEn` = 0, no rounding takes place.
- R9: The output word changes one clock edge after the cell data it is computed from.
- R10: With `oeHiN` = 0, `outHi` carries output bits 27..9. With `oeHiN` = 1, `outHi` is high-impedance.
- R11: With `oeLoN` = 0, `busB[9:1]` carries output bits 8..0. With `oeLoN` = 1, those pins are released. `busB[0]` is never driven by the block, and `busBIn` always reflects the whole bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Combine mode: 00 sum, 01 A, 10 B, 11 A−B |
| cellA | input | 28 | Accumulated result of cell A |
| cellB | input | 28 | Accumulated result of cell B |
| fmtUnsigned | input | 1 | 1 = unsigned data, 0 = two's complement |
| roundEn | input | 1 | Enables rounding |
| roundPos | input | 5 | Rounding bit position (values above 27 act as 27) |
| oeHiN | input | 1 | Active-low enable of the upper field |
| oeLoN | input | 1 | Active-low enable of the lower field on the shared bus |
| outHi | output | 19 | Output bits 27..9, three-state |
| busB | inout | 10 | Shared bus: cell B input, bits 9..1 also carry output bits 8..0 |
| busBIn | output | 10 | Value seen on the shared bus, for cell B |

## Verification
The assertions assume that the cell inputs, format, rounding controls and mode are stable around each clock edge. They also assume that the shared bus is never driven from outside while `oeLoN` is low. The bench drives every input at the falling edge. It drives `busB[9:1]` and the upper bus only while the matching enable is high. It picks random data, modes and rounding positions from a fixed seed. Directed cases cover the clamp limits, rounding at positions 0 and above 27, and a mode change that lands together with new data.

// File: rtl/fir_out_pkg.sv
package fir_out_pkg;
  parameter int WORD_W = 28;
  parameter int POS_W  = $clog2(WORD_W);

  typedef struct packed {
    logic              enA;
    logic              enB;
    logic              negB;
    logic [WORD_W-1:0] halfLsb;
    logic [WORD_W-1:0] keepMask;
  } comb_ctl_t;
endpackage

// File: rtl/fir_out_ctrl.sv
module fir_out_ctrl
  import fir_out_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             roundEn,
  input  logic [POS_W-1:0] roundPos,
  output logic [1:0]       modeReg,
  output comb_ctl_t        ctl
);
  localparam int MAX_POS = WORD_W - 1;

  logic [POS_W-1:0] effPos;

  always_ff @(posedge clk) begin
    if (!rstN) modeReg <= 2'b00;
    else       modeReg <= modeSel;
  end

  always_comb begin
    effPos = (int'(roundPos) > MAX_POS) ? POS_W'(MAX_POS) : roundPos;
  end

  always_comb begin
    ctl.enA  = (modeReg != 2'b10);
    ctl.enB  = (modeReg != 2'b01);
    ctl.negB = (modeReg == 2'b11);
  end

  genvar i;
  generate
    for (i = 0; i < WORD_W; i++) begin : g_mask
      assign ctl.keepMask[i] = !roundEn || (i >= int'(effPos));
      assign ctl.halfLsb[i]  = roundEn && (effPos != '0) && (i == int'(effPos) - 1);
    end
  endgenerate
endmodule

// File: rtl/fir_out_datapath.sv
module fir_out_datapath
  import fir_out_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] cellA,
  input  logic [WORD_W-1:0] cellB,
  input  logic              fmtUnsigned,
  input  comb_ctl_t         ctl,
  output logic [WORD_W-1:0] outWord
);
  localparam int GUARD = 3;
  localparam int EXT_W = WORD_W + GUARD;
  localparam logic signed [EXT_W-1:0] U_MAX = EXT_W'((64'sd1 <<< WORD_W) - 1);
  localparam logic signed [EXT_W-1:0] S_MAX = EXT_W'((64'sd1 <<< (WORD_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] S_MIN = -EXT_W'(64'sd1 <<< (WORD_W - 1));

  logic signed [EXT_W-1:0] extA, extB, opA, opB, total, rounded, clamped;

  always_comb begin
    extA = fmtUnsigned ? $signed({{GUARD{1'b0}}, cellA})
                       : $signed({{GUARD{cellA[WORD_W-1]}}, cellA});
    extB = fmtUnsigned ? $signed({{GUARD{1'b0}}, cellB})
                       : $signed({{GUARD{cellB[WORD_W-1]}}, cellB});
    opA  = ctl.enA ? extA : '0;
    opB  = ctl.enB ? (ctl.negB ? -extB : extB) : '0;
    total = opA + opB;
    rounded = (total + $signed({{GUARD{1'b0}}, ctl.halfLsb}))
            & $signed({{GUARD{1'b1}}, ctl.keepMask});
    if (fmtUnsigned) begin
      if (rounded < 0)          clamped = '0;
      else if (rounded > U_MAX) clamped = U_MAX;
      else                      clamped = rounded;
    end else begin
      if (rounded < S_MIN)      clamped = S_MIN;
      else if (rounded > S_MAX) clamped = S_MAX;
      else                      clamped = rounded;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outWord <= '0;
    else       outWord <= clamped[WORD_W-1:0];
  end
endmodule

// File: rtl/fir_pair_out_stage.sv
module fir_pair_out_stage
  import fir_out_pkg::*;
#(
  parameter int LO_W = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            modeSel,
  input  logic [WORD_W-1:0]     cellA,
  input  logic [WORD_W-1:0]     cellB,
  input  logic                  fmtUnsigned,
  input  logic                  roundEn,
  input  logic [POS_W-1:0]      roundPos,
  input  logic                  oeHiN,
  input  logic                  oeLoN,
  output wire  [WORD_W-LO_W-1:0] outHi,
  inout  wire  [LO_W:0]         busB,
  output logic [LO_W:0]         busBIn
);
  localparam int HI_W = WORD_W - LO_W;

  comb_ctl_t         ctl;
  logic [1:0]        modeReg;
  logic [WORD_W-1:0] outWord;

  fir_out_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .roundEn(roundEn),
    .roundPos(roundPos), .modeReg(modeReg), .ctl(ctl)
  );

  fir_out_datapath u_dp (
    .clk(clk), .rstN(rstN), .cellA(cellA), .cellB(cellB),
    .fmtUnsigned(fmtUnsigned), .ctl(ctl), .outWord(outWord)
  );

  assign outHi        = oeHiN ? {HI_W{1'bz}} : outWord[WORD_W-1:LO_W];
  assign busB[LO_W:1] = oeLoN ? {LO_W{1'bz}} : outWord[LO_W-1:0];
  assign busBIn       = busB;
endmodule

// File: rtl/fir_out_checker.sv
module fir_out_checker
  import fir_out_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] cellA,
  input logic [WORD_W-1:0] cellB,
  input logic [1:0]        modeReg,
  input logic              fmtUnsigned,
  input logic              roundEn,
  input logic [POS_W-1:0]  roundPos,
  input logic [WORD_W-1:0] outWord
);
  function automatic logic [WORD_W-1:0] lowMask(input logic [POS_W-1:0] pos);
    int p;
    p = (int'(pos) > WORD_W - 1) ? WORD_W - 1 : int'(pos);
    return WORD_W'((64'd1 << p) - 1);
  endfunction

  function automatic logic [WORD_W-1:0] satSum(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b);
    longint t;
    t = longint'($signed(a)) + longint'($signed(b));
    if (t > (64'sd1 <<< (WORD_W - 1)) - 1) t = (64'sd1 <<< (WORD_W - 1)) - 1;
    if (t < -(64'sd1 <<< (WORD_W - 1)))    t = -(64'sd1 <<< (WORD_W - 1));
    return t[WORD_W-1:0];
  endfunction

  // R8
  round_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    roundEn |=> ((outWord & lowMask($past(roundPos))) == '0) ||
                (outWord == ($past(fmtUnsigned) ? {WORD_W{1'b1}} : {1'b0, {(WORD_W-1){1'b1}}})));

  // R3
  pass_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(modeReg) == 2'b01 && !$past(roundEn)) |-> outWord == $past(cellA));

  // R3
  pass_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(modeReg) == 2'b10 && !$past(roundEn)) |-> outWord == $past(cellB));

  // R7
  unsigned_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(fmtUnsigned) && $past(modeReg) == 2'b11 && !$past(roundEn)
     && $past(cellA) < $past(cellB)) |-> outWord == '0);

  // R2
  signed_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(fmtUnsigned) && $past(modeReg) == 2'b00 && !$past(roundEn))
      |-> outWord == satSum($past(cellA), $past(cellB)));
endmodule

bind fir_pair_out_stage fir_out_checker u_chk (
  .clk(clk), .rstN(rstN), .cellA(cellA), .cellB(cellB), .modeReg(modeReg),
  .fmtUnsigned(fmtUnsigned), .roundEn(roundEn), .roundPos(roundPos), .outWord(outWord)
);

// File: tb/tb_fir_pair_out_stage.sv
module tb_fir_pair_out_stage;
  logic clk = 0;
  logic rstN = 0;
  logic [1:0] modeSel = 0;
  logic [27:0] cellA = 0, cellB = 0;
  logic fmtUnsigned = 0, roundEn = 0;
  logic [4:0] roundPos = 0;
  logic oeHiN = 0, oeLoN = 0;
  logic hiDrv = 0, loDrv = 0;
  logic [18:0] hiPat = 0;
  logic [9:0] loPat = 0;
  logic bit0 = 0;
  wire [18:0] outHi;
  wire [9:0] busB;
  logic [9:0] busBIn;
  int total = 0, bad = 0;
  logic [1:0] modeModel = 0;
  logic [27:0] expWord = 0;
  bit finished = 0;

  assign outHi = hiDrv ? hiPat : 19'bz;
  assign busB[9:1] = loDrv ? loPat[9:1] : 9'bz;
  assign busB[0] = bit0;

  always #4 clk = ~clk;

  fir_pair_out_stage dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .cellA(cellA), .cellB(cellB),
    .fmtUnsigned(fmtUnsigned), .roundEn(roundEn), .roundPos(roundPos),
    .oeHiN(oeHiN), .oeLoN(oeLoN), .outHi(outHi), .busB(busB), .busBIn(busBIn)
  );

  function automatic logic [27:0] model(logic [27:0] a, logic [27:0] b, logic [1:0] m,
                                        logic uns, logic ren, logic [4:0] pos);
    longint ea, eb, t;
    int p;
    ea = uns ? longint'(a) : longint'($signed(a));
    eb = uns ? longint'(b) : longint'($signed(b));
    case (m)
      2'b00: t = ea + eb;
      2'b01: t = ea;
      2'b10: t = eb;
      default: t = ea - eb;
    endcase
    if (ren) begin
      p = (int'(pos) > 27) ? 27 : int'(pos);
      if (p > 0) t = t + (64'sd1 <<< (p - 1));
      t = t & ~((64'sd1 <<< p) - 1);
    end
    if (uns) begin
      if (t < 0) t = 0;
      if (t > (64'sd1 <<< 28) - 1) t = (64'sd1 <<< 28) - 1;
    end else begin
      if (t > (64'sd1 <<< 27) - 1) t = (64'sd1 <<< 27) - 1;
      if (t < -(64'sd1 <<< 27)) t = -(64'sd1 <<< 27);
    end
    return t[27:0];
  endfunction

  task automatic check(string req, logic [27:0] act, logic [27:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] pins();
    return {outHi, busB[9:1]};
  endfunction

  task automatic drive(logic [27:0] a, logic [27:0] b, logic [1:0] m,
                       logic uns, logic ren, logic [4:0] pos);
    cellA = a; cellB = b; modeSel = m; fmtUnsigned = uns; roundEn = ren; roundPos = pos;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    expWord = model(cellA, cellB, modeModel, fmtUnsigned, roundEn, roundPos);
    modeModel = modeSel;
    @(negedge clk);
  endtask

  task automatic runChk(string req, logic [27:0] a, logic [27:0] b, logic [1:0] m,
                        logic uns, logic ren, logic [4:0] pos);
    drive(a, b, m, uns, ren, pos);
    step();
    drive(a, b, m, uns, ren, pos);
    step();
    check(req, pins(), expWord);
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0c17);
    drive(28'h1234567, 28'h0abcdef, 2'b11, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R1 reset output", pins(), 28'h0);
    rstN = 1;
    modeModel = 2'b00;
    drive(28'd10, 28'd3, 2'b00, 0, 0, 0);
    step();
    check("R1 R2 mode resets to sum", pins(), 28'd13);

    runChk("R2 sum", 28'd100, 28'hFFFFFF6, 2'b00, 0, 0, 0);
    runChk("R3 A only", 28'h0ABCDEF, 28'h1111111, 2'b01, 0, 0, 0);
    runChk("R3 B only", 28'h0ABCDEF, 28'h1111111, 2'b10, 0, 0, 0);
    runChk("R4 A-B", 28'd50, 28'd80, 2'b11, 0, 0, 0);
    check("R4 A-B value", pins(), 28'hFFFFFE2);
    runChk("R6 signed clamp high", 28'h7FFFFFF, 28'h7FFFFFF, 2'b00, 0, 0, 0);
    check("R6 max", pins(), 28'h7FFFFFF);
    runChk("R6 signed clamp low", 28'h8000000, 28'h8000000, 2'b00, 0, 0, 0);
    check("R6 min", pins(), 28'h8000000);
    runChk("R7 unsigned floor", 28'd5, 28'd9, 2'b11, 1, 0, 0);
    check("R7 zero", pins(), 28'h0);
    runChk("R7 unsigned clamp", 28'hFFFFFFF, 28'hFFFFFFF, 2'b00, 1, 0, 0);
    check("R7 max", pins(), 28'hFFFFFFF);
    runChk("R8 round pos4", 28'h18, 28'h0, 2'b01, 0, 1, 5'd4);
    check("R8 round value", pins(), 28'h20);
    runChk("R8 round pos0", 28'h1F, 28'h0, 2'b01, 0, 1, 5'd0);
    check("R8 pos0 unchanged", pins(), 28'h1F);
    runChk("R8 pos31 as 27", 28'h4000000, 28'h0, 2'b01, 1, 1, 5'd31);
    check("R8 pos31 value", pins(), 28'h8000000);

    // R5 and R9: mode and data change on the same edge
    drive(28'd5, 28'd7, 2'b10, 0, 0, 0); step();
    drive(28'd5, 28'd7, 2'b01, 0, 0, 0); step();
    check("R5 old mode holds", pins(), 28'd7);
    drive(28'd9, 28'd7, 2'b01, 0, 0, 0); step();
    check("R5 R9 new mode and new data", pins(), 28'd9);

    // R10 upper field released
    oeHiN = 1; #1; hiDrv = 1; hiPat = 19'h5A5A5; #1;
    check("R10 hi released", {9'h0, outHi}, {9'h0, 19'h5A5A5});
    hiDrv = 0; oeHiN = 0; #1;
    check("R10 hi driven", {9'h0, outHi}, {9'h0, expWord[27:9]});
    // R11 lower field released, bit 0 input only
    oeLoN = 1; #1; loDrv = 1; loPat = 10'h2B4; bit0 = 1; #1;
    check("R11 bus released", {18'h0, busBIn}, {18'h0, 10'h2B5});
    loDrv = 0; oeLoN = 0; bit0 = 0; #1;
    check("R11 bit0 input", {27'h0, busBIn[0]}, 28'h0);
    bit0 = 1; #1;
    check("R11 bit0 follows", {27'h0, busBIn[0]}, 28'h1);
    check("R11 lo driven", {18'h0, busBIn[9:1], 1'b0}, {18'h0, expWord[8:0], 1'b0});
    bit0 = 0;

    for (int i = 0; i < 400; i++) begin
      drive($urandom, $urandom, 2'($urandom), 1'($urandom), 1'($urandom), 5'($urandom));
      step();
      check("R2 R3 R4 R6 R7 R8 random", pins(), expWord);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule